// File: doc/BRIEF.md
# Cursor-Addressed Display RAM Access Port

This block lets a host read and write display memory through an auto-stepping cursor. The cursor is an 11-bit address made of a 7-bit upper half and a 4-bit lower half. Each half is a presettable down-counter. Every accepted access uses the current cursor and then steps it down by one. The lower half wraps to one less than the programmed line width in bytes. The upper half wraps to a top value that depends on the selected memory size.

Reads go through an output holding register. During a read strobe the host sees the byte fetched by the previous read, while the byte at the cursor is fetched for the next one. After the cursor is preset, the first read is therefore a dummy. The memory is an external synchronous single-port array with one cycle of read latency. Addresses at or above the configured size are never written, and reads from them fetch 00h.

Top module: `cursor_port`

## Requirements
- R1: After reset the cursor is 0, so `ramAddr` is 000h. `ramWe` is low and `hostRdData` is 00h.
- R2: `ramAddr` is always {upper, lower}, with the upper half in bits 10:4 and the lower half in bits 3:0. A pulse on `loadUp` or `loadLow` replaces that half from `upIn` or `lowIn` on the next cycle. With no strobe the cursor holds.
- R3: An accepted access with the lower half nonzero decrements the lower half only. With the lower half at 0, the lower half reloads to `dispNum`−1 and the upper half decrements.
- R4: When the upper half must decrement from 0, it reloads to 7Fh if `bigRam`=1 and to 3Fh if `bigRam`=0.
- R5: In a write cycle (`wrStb`=1) with an in-range cursor, `ramWe` is high in that same cycle, with `ramWdata`=`wrData` at `ramAddr`=cursor. The cursor then steps.
- R6: In a read cycle, `hostRdData` shows the byte fetched by the previous accepted read. The new fetch appears on `hostRdData` from the next cycle on, and this holds for back-to-back reads as well. With no read, `hostRdData` is steady.
- R7: Presetting either cursor half leaves the output holding register unchanged. The first read after a preset returns the byte fetched before the preset.
- R8: The configured size is 640 bytes when `bigRam`=0 and 1280 bytes when `bigRam`=1. A cursor at or above this size never asserts `ramWe`, and a read there fetches 00h. The cursor still steps.
- R9: If `wrStb` and `rdStb` are both high, only the write is performed. The read is ignored, the holding register is untouched and the cursor steps once.
- R10: A preset in the same cycle as an access wins for the half being loaded. The access uses the old cursor, and the other half steps as R3 and R4 require.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadLow | input | 1 | Preset strobe for the lower cursor half |
| loadUp | input | 1 | Preset strobe for the upper cursor half |
| lowIn | input | 4 | Preset value for the lower half |
| upIn | input | 7 | Preset value for the upper half |
| dispNum | input | 4 | Bytes per display line; the lower half wraps to this minus one |
| bigRam | input | 1 | 1 selects 1280-byte memory, 0 selects 640-byte memory |
| wrStb | input | 1 | Host write strobe, one access per high cycle |
| rdStb | input | 1 | Host read strobe, one access per high cycle |
| wrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Byte returned to the host |
| ramAddr | output | 11 | Memory address (the cursor) |
| ramWe | output | 1 | Memory write enable |
| ramWdata | output | 8 | Memory write byte |
| ramRdata | input | 8 | Memory read byte, valid one cycle after the address |

## Verification
The hardest state to reach is the double wrap, where both halves sit at zero. The next access must then reload the upper half to a size-dependent top that points outside the configured memory. A long sweep of writes with a narrow line width gets there naturally. It starts from a low cursor, passes through every lower and upper wrap, and runs into the out-of-range region. The sweep then repeats as reads, with back-to-back and spaced reads mixed and with a cursor preset in the middle, so that the stale first read and the fetch bypass are both checked against a model of what was stored.

// File: rtl/cursor_port_pkg.sv
package cursor_port_pkg;

  // Strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic doWrite;   // accepted write this cycle
    logic doRead;    // accepted read this cycle
    logic step;      // cursor advances after this cycle
    logic loadLow;   // preset lower half
    logic loadUp;    // preset upper half
    logic capture;   // memory data from last cycle's read is valid now
  } accCtl_t;

endpackage

// File: rtl/cursor_port_ctrl.sv
module cursor_port_ctrl
  import cursor_port_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrStb,
  input  logic    rdStb,
  input  logic    loadLow,
  input  logic    loadUp,
  output accCtl_t ctl
);

  logic rdAccept;
  logic pendQ;

  // write has priority over a simultaneous read
  assign rdAccept = rdStb && !wrStb;

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= rdAccept;
  end

  always_comb begin
    ctl.doWrite = wrStb;
    ctl.doRead  = rdAccept;
    ctl.step    = wrStb || rdAccept;
    ctl.loadLow = loadLow;
    ctl.loadUp  = loadUp;
    ctl.capture = pendQ;
  end

endmodule

// File: rtl/cursor_port_dp.sv
module cursor_port_dp
  import cursor_port_pkg::*;
#(
  parameter int LOW_W       = 4,
  parameter int UP_W        = 7,
  parameter int DATA_W      = 8,
  parameter int SMALL_BYTES = 640,
  parameter int LARGE_BYTES = 1280
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  accCtl_t                 ctl,
  input  logic [LOW_W-1:0]        lowIn,
  input  logic [UP_W-1:0]         upIn,
  input  logic [LOW_W-1:0]        dispNum,
  input  logic                    bigRam,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [DATA_W-1:0]       ramRdata,
  output logic [UP_W+LOW_W-1:0]   ramAddr,
  output logic                    ramWe,
  output logic [DATA_W-1:0]       ramWdata,
  output logic [DATA_W-1:0]       hostRdData
);

  localparam int ADDR_W = UP_W + LOW_W;
  localparam logic [UP_W-1:0]   TOP_BIG   = {UP_W{1'b1}};
  localparam logic [UP_W-1:0]   TOP_SMALL = TOP_BIG >> 1;
  localparam logic [ADDR_W:0]   LIM_SMALL = (ADDR_W+1)'(SMALL_BYTES);
  localparam logic [ADDR_W:0]   LIM_BIG   = (ADDR_W+1)'(LARGE_BYTES);

  logic [LOW_W-1:0]  lowQ, lowNext, lowReload;
  logic [UP_W-1:0]   upQ, upNext, upTop;
  logic [ADDR_W:0]   sizeLim;
  logic              inRange;
  logic              capOkQ;
  logic [DATA_W-1:0] fetched;
  logic [DATA_W-1:0] holdQ;

  assign lowReload = dispNum - LOW_W'(1);
  assign upTop     = bigRam ? TOP_BIG : TOP_SMALL;
  assign sizeLim   = bigRam ? LIM_BIG : LIM_SMALL;

  // next cursor: a preset wins for its own half
  always_comb begin
    lowNext = lowQ;
    upNext  = upQ;
    if (ctl.step) begin
      if (lowQ == '0) begin
        lowNext = lowReload;
        upNext  = (upQ == '0) ? upTop : upQ - UP_W'(1);
      end else begin
        lowNext = lowQ - LOW_W'(1);
      end
    end
    if (ctl.loadLow) lowNext = lowIn;
    if (ctl.loadUp)  upNext  = upIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowQ <= '0;
      upQ  <= '0;
    end else begin
      lowQ <= lowNext;
      upQ  <= upNext;
    end
  end

  assign ramAddr  = {upQ, lowQ};
  assign inRange  = {1'b0, ramAddr} < sizeLim;
  assign ramWe    = ctl.doWrite && inRange;
  assign ramWdata = wrData;

  // remember whether the pending fetch hit real memory
  always_ff @(posedge clk) begin
    if (!rstN)           capOkQ <= 1'b0;
    else if (ctl.doRead) capOkQ <= inRange;
  end

  assign fetched = capOkQ ? ramRdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN)            holdQ <= '0;
    else if (ctl.capture) holdQ <= fetched;
  end

  // bypass so a back-to-back read sees the byte fetched one cycle earlier
  assign hostRdData = ctl.capture ? fetched : holdQ;

endmodule

// File: rtl/cursor_port.sv
module cursor_port
  import cursor_port_pkg::*;
#(
  parameter int LOW_W       = 4,
  parameter int UP_W        = 7,
  parameter int DATA_W      = 8,
  parameter int SMALL_BYTES = 640,
  parameter int LARGE_BYTES = 1280
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  loadLow,
  input  logic                  loadUp,
  input  logic [LOW_W-1:0]      lowIn,
  input  logic [UP_W-1:0]       upIn,
  input  logic [LOW_W-1:0]      dispNum,
  input  logic                  bigRam,
  input  logic                  wrStb,
  input  logic                  rdStb,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     hostRdData,
  output logic [UP_W+LOW_W-1:0] ramAddr,
  output logic                  ramWe,
  output logic [DATA_W-1:0]     ramWdata,
  input  logic [DATA_W-1:0]     ramRdata
);

  accCtl_t ctl;

  cursor_port_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrStb   (wrStb),
    .rdStb   (rdStb),
    .loadLow (loadLow),
    .loadUp  (loadUp),
    .ctl     (ctl)
  );

  cursor_port_dp #(
    .LOW_W       (LOW_W),
    .UP_W        (UP_W),
    .DATA_W      (DATA_W),
    .SMALL_BYTES (SMALL_BYTES),
    .LARGE_BYTES (LARGE_BYTES)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .lowIn      (lowIn),
    .upIn       (upIn),
    .dispNum    (dispNum),
    .bigRam     (bigRam),
    .wrData     (wrData),
    .ramRdata   (ramRdata),
    .ramAddr    (ramAddr),
    .ramWe      (ramWe),
    .ramWdata   (ramWdata),
    .hostRdData (hostRdData)
  );

endmodule

// File: rtl/cursor_port_chk.sv
module cursor_port_chk #(
  parameter int LOW_W       = 4,
  parameter int UP_W        = 7,
  parameter int DATA_W      = 8,
  parameter int SMALL_BYTES = 640,
  parameter int LARGE_BYTES = 1280
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  loadLow,
  input logic                  loadUp,
  input logic [LOW_W-1:0]      lowIn,
  input logic [LOW_W-1:0]      dispNum,
  input logic                  bigRam,
  input logic                  wrStb,
  input logic                  rdStb,
  input logic [DATA_W-1:0]     wrData,
  input logic [DATA_W-1:0]     hostRdData,
  input logic [UP_W+LOW_W-1:0] ramAddr,
  input logic                  ramWe,
  input logic [DATA_W-1:0]     ramWdata
);

  localparam int ADDR_W = UP_W + LOW_W;
  localparam logic [UP_W-1:0] TOPB = {UP_W{1'b1}};
  localparam logic [UP_W-1:0] TOPS = TOPB >> 1;

  logic [ADDR_W:0]   lim;
  logic              acc;
  logic [LOW_W-1:0]  curLow;
  logic [UP_W-1:0]   curUp;

  assign lim    = bigRam ? (ADDR_W+1)'(LARGE_BYTES) : (ADDR_W+1)'(SMALL_BYTES);
  assign acc    = wrStb || rdStb;
  assign curLow = ramAddr[LOW_W-1:0];
  assign curUp  = ramAddr[ADDR_W-1:LOW_W];

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !acc && !loadLow && !loadUp |=> $stable(ramAddr));

  // R3
  low_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc && !loadLow && !loadUp && curLow != '0
    |=> curLow == $past(curLow) - LOW_W'(1) && curUp == $past(curUp));

  // R3
  low_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc && !loadLow && !loadUp && curLow == '0 && curUp != '0
    |=> curLow == $past(dispNum) - LOW_W'(1) && curUp == $past(curUp) - UP_W'(1));

  // R4
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc && !loadUp && curLow == '0 && curUp == '0
    |=> curUp == ($past(bigRam) ? TOPB : TOPS));

  // R5
  write_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb && ({1'b0, ramAddr} < lim) |-> ramWe && ramWdata == wrData);

  // R8
  no_oob_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> wrStb && ({1'b0, ramAddr} < lim));

  // R6
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb && !$past(rdStb) |=> $stable(hostRdData));

  // R10
  preset_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadLow |=> curLow == $past(lowIn));

endmodule

bind cursor_port cursor_port_chk #(
  .LOW_W       (LOW_W),
  .UP_W        (UP_W),
  .DATA_W      (DATA_W),
  .SMALL_BYTES (SMALL_BYTES),
  .LARGE_BYTES (LARGE_BYTES)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .loadLow    (loadLow),
  .loadUp     (loadUp),
  .lowIn      (lowIn),
  .dispNum    (dispNum),
  .bigRam     (bigRam),
  .wrStb      (wrStb),
  .rdStb      (rdStb),
  .wrData     (wrData),
  .hostRdData (hostRdData),
  .ramAddr    (ramAddr),
  .ramWe      (ramWe),
  .ramWdata   (ramWdata)
);

// File: tb/cursor_port_test.sv
module cursor_port_test;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        loadLow, loadUp, bigRam, wrStb, rdStb;
  logic [3:0]  lowIn, dispNum;
  logic [6:0]  upIn;
  logic [7:0]  wrData, hostRdData, ramWdata, ramRdata;
  logic [10:0] ramAddr;
  logic        ramWe;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic [3:0] mLow;
  logic [6:0] mUp;
  logic [7:0] lastFetch;
  logic [7:0] shadow [2048];
  logic [7:0] mem [2048];

  always #(PERIOD/2) clk = ~clk;

  cursor_port uut (
    .clk(clk), .rstN(rstN), .loadLow(loadLow), .loadUp(loadUp),
    .lowIn(lowIn), .upIn(upIn), .dispNum(dispNum), .bigRam(bigRam),
    .wrStb(wrStb), .rdStb(rdStb), .wrData(wrData), .hostRdData(hostRdData),
    .ramAddr(ramAddr), .ramWe(ramWe), .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  // synchronous single-port memory, one cycle read latency
  always @(posedge clk) begin
    if (ramWe) mem[ramAddr] <= ramWdata;
    ramRdata <= mem[ramAddr];
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit inSize(input logic [10:0] a);
    return int'(a) < (bigRam ? 1280 : 640);
  endfunction

  // one cycle of stimulus, checks, then model update
  task automatic op(input bit w, input bit r, input bit ll, input bit lu,
                    input logic [7:0] wd, input logic [3:0] lv, input logic [6:0] uv,
                    input string rdTag);
    logic [10:0] a;
    bit inr;
    bit acc;
    @(negedge clk);
    wrStb = w; rdStb = r; loadLow = ll; loadUp = lu;
    wrData = wd; lowIn = lv; upIn = uv;
    #1;
    a   = {mUp, mLow};
    inr = inSize(a);
    chk("R3 cursor address", int'(ramAddr), int'(a));
    chk(inr ? "R5 write enable" : "R8 write enable", int'(ramWe), int'(w && inr));
    if (w && inr) chk("R5 write data", int'(ramWdata), int'(wd));
    if (r && !w) begin
      chk(rdTag, int'(hostRdData), int'(lastFetch));
      lastFetch = inr ? shadow[a] : 8'h00;
    end
    if (w && inr) shadow[a] = wd;
    acc = w || r;
    if (acc) begin
      if (mLow == 4'd0) begin
        mLow = dispNum - 4'd1;
        mUp  = (mUp == 7'd0) ? (bigRam ? 7'h7F : 7'h3F) : mUp - 7'd1;
      end else begin
        mLow = mLow - 4'd1;
      end
    end
    if (ll) mLow = lv;
    if (lu) mUp  = uv;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    wrStb = 0; rdStb = 0; loadLow = 0; loadUp = 0;
    #1;
    chk("R2 idle address", int'(ramAddr), int'({mUp, mLow}));
    chk("R2 idle write enable", int'(ramWe), 0);
    chk(tag, int'(hostRdData), int'(lastFetch));
  endtask

  task automatic preset(input logic [6:0] uv, input logic [3:0] lv);
    op(0, 0, 1, 1, 8'h00, lv, uv, "");
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin
      mem[i] = 8'h00;
      shadow[i] = 8'h00;
    end
    rstN = 0; loadLow = 0; loadUp = 0; lowIn = 0; upIn = 0;
    dispNum = 4'd3; bigRam = 0; wrStb = 0; rdStb = 0; wrData = 0;
    mLow = 0; mUp = 0; lastFetch = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 reset address", int'(ramAddr), 0);
    chk("R1 reset write enable", int'(ramWe), 0);
    chk("R1 reset read data", int'(hostRdData), 0);
    rstN = 1;

    // R2 preset both halves
    preset(7'h02, 4'h1);
    idle("R2 output after preset");
    chk("R2 preset address", int'(ramAddr), 11'h021);

    // write sweep through lower wraps (R3), upper wrap (R4), out of range (R8)
    for (int i = 0; i < 200; i++)
      op(1, 0, 0, 0, 8'((i * 7 + 3) ^ 8'h5A), 4'h0, 7'h00, "");
    idle("R6 output after writes");

    // read sweep, mixing back-to-back and spaced reads, with a mid-sweep preset
    preset(7'h02, 4'h1);
    for (int i = 0; i < 200; i++) begin
      if (i == 97) begin
        preset(7'h01, 4'h2);
        op(0, 1, 0, 0, 8'h00, 4'h0, 7'h00, "R7 first read after preset is stale");
      end else begin
        op(0, 1, 0, 0, 8'h00, 4'h0, 7'h00, "R6 read returns previous fetch");
      end
      if (i % 5 == 4) idle("R6 fetch visible after read");
    end
    idle("R6 fetch after last read");

    // R7: a lone preset leaves the held byte untouched
    preset(7'h00, 4'h0);
    idle("R7 output unchanged by preset");

    // R9: write and read together, write wins, output unchanged
    op(1, 1, 0, 0, 8'hC3, 4'h0, 7'h00, "");
    idle("R9 read ignored with write");
    chk("R9 single step", int'(ramAddr), 11'h3F2);
    preset(7'h00, 4'h0);
    op(0, 1, 0, 0, 8'h00, 4'h0, 7'h00, "R9 stale read");
    op(0, 1, 0, 0, 8'h00, 4'h0, 7'h00, "R9 written byte read back");
    idle("R9 output");

    // big memory: upper wraps to 7Fh (R4), address beyond 1280 (R8)
    bigRam = 1;
    preset(7'h00, 4'h0);
    op(1, 0, 0, 0, 8'h11, 4'h0, 7'h00, "");
    idle("R4 output");
    chk("R4 big wrap address", int'(ramAddr), 11'h7F2);
    op(1, 0, 0, 0, 8'h22, 4'h0, 7'h00, "");
    preset(7'h4F, 4'h0);
    op(1, 0, 0, 0, 8'h33, 4'h0, 7'h00, "");
    preset(7'h7F, 4'h2);
    op(0, 1, 0, 0, 8'h00, 4'h0, 7'h00, "R8 dummy read");
    op(0, 1, 0, 0, 8'h00, 4'h0, 7'h00, "R8 out of range reads zero");
    idle("R8 output");

    // R10: preset lower half while writing; upper still steps from lower underflow
    preset(7'h05, 4'h0);
    op(1, 0, 1, 0, 8'h44, 4'h7, 7'h00, "");
    idle("R10 output");
    chk("R10 lower preset wins", int'(ramAddr), 11'h047);
    op(0, 1, 0, 1, 8'h00, 4'h0, 7'h10, "R10 read with upper preset");
    idle("R10 output after read");
    chk("R10 upper preset wins", int'(ramAddr), 11'h106);

    // dispNum change: lower reload uses new width (R3)
    dispNum = 4'd10;
    preset(7'h03, 4'h0);
    op(1, 0, 0, 0, 8'h55, 4'h0, 7'h00, "");
    idle("R3 output");
    chk("R3 reload to width minus one", int'(ramAddr), 11'h029);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule